// File: doc/BRIEF.md
# Two-Port Shared Memory with Collision Arbitration

This block is a 2048-word by 8-bit memory that two agents, called left and right, can use at the same time. Each side has its own enable, write strobe, address, write data and read data. When both enabled sides point at the same word, the block settles the conflict by raising an active-low busy flag on one side and suppressing that side's write. Reads from a flagged side still return the stored word.

A mode input sets the role of the block. In arbiter mode it decides which side loses and drives the busy outputs. In follower mode it does no arbitration of its own. Its busy outputs stay inactive, and its busy inputs act only as per-side write blocks. Several copies can then share the decision of one arbiter copy, so that a wide word is built from several narrow ones.

Every access is captured at a rising clock edge. The busy decision for that access is registered at the same edge. The write, gated by the settled busy state, commits at the following edge, which is also when the read data is loaded.

Top module: `dparb_ram`

## Requirements
- R1: The store holds 2048 words of 8 bits, and each side reaches it on its own. An access presented before rising edge N is captured at N. Its read data appears on that side's read output after edge N+1 and holds the word as it stood before any write committed at N+1.
- R2: Out of reset both busy outputs are high. In arbiter mode (mode input high), the busy outputs are active low and registered. Between edges N and N+1 they show the decision for the accesses captured at N.
- R3: The arbitration uses only the enables and addresses. A collision flags a side busy whether the accesses are reads or writes.
- R4: First come keeps access. If one side held the same enabled address in the previous cycle and the other side has just moved onto it, the newcomer is flagged busy. The flag stays for as long as both keep that address.
- R5: If both sides move onto the same address in the same cycle, left wins and right is flagged busy.
- R6: The two busy outputs are never low at the same time.
- R7: A write from a side whose access is flagged busy does not change the store. A read from a flagged side still returns the stored word.
- R8: With both sides enabled on different addresses, no busy is raised and both writes commit at the same edge.
- R9: In follower mode (mode input low), both busy outputs are high from the cycle after the mode is sampled low. A low busy input blocks the write of that side's access captured at the previous edge. The input is sampled during the cycle after capture, once the arbiter's flag has settled.
- R10: A busy flag returns high one cycle after the contention ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | 1: arbiter role, 0: follower role |
| l_en | input | 1 | Left access enable |
| l_we | input | 1 | Left write strobe (1 write, 0 read) |
| l_addr | input | 11 | Left word address |
| l_wdata | input | 8 | Left write data |
| l_rdata | output | 8 | Left read data |
| l_busy_n | output | 1 | Left busy flag out, active low |
| l_busy_in_n | input | 1 | Left write block in follower mode, active low |
| r_en | input | 1 | Right access enable |
| r_we | input | 1 | Right write strobe (1 write, 0 read) |
| r_addr | input | 11 | Right word address |
| r_wdata | input | 8 | Right write data |
| r_rdata | output | 8 | Right read data |
| r_busy_n | output | 1 | Right busy flag out, active low |
| r_busy_in_n | input | 1 | Right write block in follower mode, active low |

## Verification
The bench targets several corner cases:
- A same-cycle tie on a fresh address. A design without a left-wins rule would flag the wrong side or both sides.
- A late arrival against an established holder. Here a design that reevaluates ownership every cycle would hand access to the newcomer.
- A collision made only of reads. A design that keys busy on the write strobe would stay silent.
- The release cycle. A design with an extra stage would keep busy low too long.
- Follower mode. A design that still arbitrates locally would let its own flags leak out, and one that samples the busy input in the wrong cycle would drop or corrupt the inhibited write.

// File: rtl/dparb_pkg.sv
package dparb_pkg;

  typedef enum logic [1:0] {
    ARB_CLEAR      = 2'd0,
    ARB_BUSY_LEFT  = 2'd1,
    ARB_BUSY_RIGHT = 2'd2
  } arb_res_t;

  // Decide the loser of a collision from who was already on the address.
  function automatic arb_res_t resolve(input logic clash, input logic l_stay,
                                       input logic r_stay, input logic l_was_busy);
    if (!clash) return ARB_CLEAR;
    if (l_stay && !r_stay) return ARB_BUSY_RIGHT;
    if (r_stay && !l_stay) return ARB_BUSY_LEFT;
    if (l_stay && r_stay && l_was_busy) return ARB_BUSY_LEFT;
    return ARB_BUSY_RIGHT;
  endfunction

endpackage

// File: rtl/dparb_arbiter.sv
module dparb_arbiter
  import dparb_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_mode,
  input  logic          l_en,
  input  logic [AW-1:0] l_addr,
  input  logic          r_en,
  input  logic [AW-1:0] r_addr,
  output logic          l_busy,
  output logic          r_busy
);

  logic          l_seen_en, r_seen_en;
  logic [AW-1:0] l_seen_addr, r_seen_addr;
  logic          clash, l_stay, r_stay;
  arb_res_t      verdict;

  assign clash   = l_en && r_en && (l_addr == r_addr);
  assign l_stay  = l_seen_en && (l_seen_addr == l_addr);
  assign r_stay  = r_seen_en && (r_seen_addr == r_addr);
  assign verdict = resolve(clash, l_stay, r_stay, l_busy);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_seen_en   <= 1'b0;
      r_seen_en   <= 1'b0;
      l_seen_addr <= '0;
      r_seen_addr <= '0;
      l_busy      <= 1'b0;
      r_busy      <= 1'b0;
    end else begin
      l_seen_en   <= l_en;
      r_seen_en   <= r_en;
      l_seen_addr <= l_addr;
      r_seen_addr <= r_addr;
      l_busy      <= master_mode && (verdict == ARB_BUSY_LEFT);
      r_busy      <= master_mode && (verdict == ARB_BUSY_RIGHT);
    end
  end

  // R6
  busy_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_busy && r_busy));

  // R8
  no_clash_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clash |=> (!l_busy && !r_busy));

  // R5
  tie_left_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && clash && !l_stay && !r_stay) |=> (r_busy && !l_busy));

  // R4
  holder_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && clash && l_stay && !r_stay) |=> r_busy);

endmodule

// File: rtl/dparb_store.sv
module dparb_store #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_rd,
  input  logic          a_wr,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_rd,
  input  logic          b_wr,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (a_wr) cells[a_addr] <= a_wdata;
    if (b_wr) cells[b_addr] <= b_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_rd) a_rdata <= cells[a_addr];
      if (b_rd) b_rdata <= cells[b_addr];
    end
  end

  // R6
  distinct_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wr && b_wr) |-> (a_addr != b_addr));

endmodule

// File: rtl/dparb_ram.sv
module dparb_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_mode,
  input  logic          l_en,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_busy_n,
  input  logic          l_busy_in_n,
  input  logic          r_en,
  input  logic          r_we,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_busy_n,
  input  logic          r_busy_in_n
);

  localparam int NP = 2;

  logic [NP-1:0] in_en, in_we, busy_ext_n;
  logic [AW-1:0] in_addr [NP];
  logic [DW-1:0] in_data [NP];

  logic [NP-1:0] cap_en, cap_we, busy_q, inhibit, commit;
  logic [AW-1:0] cap_addr [NP];
  logic [DW-1:0] cap_data [NP];

  assign in_en      = {r_en, l_en};
  assign in_we      = {r_we, l_we};
  assign busy_ext_n = {r_busy_in_n, l_busy_in_n};
  assign in_addr[0] = l_addr;
  assign in_addr[1] = r_addr;
  assign in_data[0] = l_wdata;
  assign in_data[1] = r_wdata;

  for (genvar p = 0; p < NP; p++) begin : g_side
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cap_en[p]   <= 1'b0;
        cap_we[p]   <= 1'b0;
        cap_addr[p] <= '0;
        cap_data[p] <= '0;
      end else begin
        cap_en[p]   <= in_en[p];
        cap_we[p]   <= in_we[p];
        cap_addr[p] <= in_addr[p];
        cap_data[p] <= in_data[p];
      end
    end
    assign inhibit[p] = master_mode ? busy_q[p] : !busy_ext_n[p];
    assign commit[p]  = cap_en[p] && cap_we[p] && !inhibit[p];
  end

  dparb_arbiter #(.AW(AW)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_mode (master_mode),
    .l_en        (l_en),
    .l_addr      (l_addr),
    .r_en        (r_en),
    .r_addr      (r_addr),
    .l_busy      (busy_q[0]),
    .r_busy      (busy_q[1])
  );

  dparb_store #(.AW(AW), .DW(DW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_rd    (cap_en[0]),
    .a_wr    (commit[0]),
    .a_addr  (cap_addr[0]),
    .a_wdata (cap_data[0]),
    .a_rdata (l_rdata),
    .b_rd    (cap_en[1]),
    .b_wr    (commit[1]),
    .b_addr  (cap_addr[1]),
    .b_wdata (cap_data[1]),
    .b_rdata (r_rdata)
  );

  assign l_busy_n = !busy_q[0];
  assign r_busy_n = !busy_q[1];

  // R9
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |=> (l_busy_n && r_busy_n));

endmodule

// File: tb/dparb_ram_test.sv
module dparb_ram_test;

  localparam int AW = 11;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, master_mode;
  logic l_en, l_we, l_busy_in_n, r_en, r_we, r_busy_in_n;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_busy_n, r_busy_n;

  dparb_ram #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_en(l_en), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_busy_n(l_busy_n), .l_busy_in_n(l_busy_in_n),
    .r_en(r_en), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_busy_n(r_busy_n), .r_busy_in_n(r_busy_in_n)
  );

  typedef struct {
    int         due;
    int         kind;   // 0 left busy, 1 right busy, 2 left read, 3 right read
    logic [7:0] val;
    string      tag;
  } exp_t;

  exp_t       sb[$];
  int         cyc = 0;
  int         vectors = 0;
  int         misses = 0;
  logic [7:0] ref_mem [2048];

  // Bench model state: pending accesses and modelled busy
  bit         pend_en [2];
  bit         pend_we [2];
  int         pend_addr [2];
  logic [7:0] pend_data [2];
  string      pend_tag [2];
  bit         mb [2];

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare expectations as their cycle comes up
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      logic [7:0] act;
      e = sb.pop_front();
      case (e.kind)
        0: act = {7'd0, l_busy_n};
        1: act = {7'd0, r_busy_n};
        2: act = l_rdata;
        default: act = r_rdata;
      endcase
      vectors++;
      if (e.due != cyc || act !== e.val) begin
        misses++;
        $display("FAIL %s kind=%0d cycle=%0d actual=%h expected=%h",
                 e.tag, e.kind, cyc, act, e.val);
      end
    end
  end

  task automatic push(input int kind, input logic [7:0] val, input string tag);
    exp_t e;
    e.due = cyc + 1; e.kind = kind; e.val = val; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic drive(input bit m,
                       input bit le, input bit lw, input int la, input int ld,
                       input bit re, input bit rw, input int ra, input int rd,
                       input bit lbi, input bit rbi, input string tag);
    bit nb [2];
    bit coll, lh, rh, blk;
    @(posedge clk); #2;
    master_mode = m;
    l_en = le; l_we = lw; l_addr = la[AW-1:0]; l_wdata = ld[7:0]; l_busy_in_n = lbi;
    r_en = re; r_we = rw; r_addr = ra[AW-1:0]; r_wdata = rd[7:0]; r_busy_in_n = rbi;
    // reads of the access captured last edge see the store before this edge's writes
    for (int p = 0; p < 2; p++)
      if (pend_en[p] && !pend_we[p]) push(2 + p, ref_mem[pend_addr[p]], pend_tag[p]);
    for (int p = 0; p < 2; p++) begin
      blk = m ? mb[p] : ((p == 0) ? !lbi : !rbi);
      if (pend_en[p] && pend_we[p] && !blk) ref_mem[pend_addr[p]] = pend_data[p];
    end
    // arbitration restated from the requirements
    coll = le && re && (la == ra);
    lh = pend_en[0] && (pend_addr[0] == la);
    rh = pend_en[1] && (pend_addr[1] == ra);
    nb[0] = 1'b0; nb[1] = 1'b0;
    if (m && coll) begin
      if (lh != rh) begin
        nb[0] = rh; nb[1] = lh;           // newcomer loses (R4)
      end else if (lh && rh && (mb[0] || mb[1])) begin
        nb[0] = mb[0]; nb[1] = mb[1];     // owner keeps
      end else begin
        nb[1] = 1'b1;                     // tie: left wins (R5)
      end
    end
    push(0, {7'd0, !nb[0]}, tag);
    push(1, {7'd0, !nb[1]}, tag);
    pend_en[0] = le; pend_we[0] = lw; pend_addr[0] = la; pend_data[0] = ld[7:0]; pend_tag[0] = tag;
    pend_en[1] = re; pend_we[1] = rw; pend_addr[1] = ra; pend_data[1] = rd[7:0]; pend_tag[1] = tag;
    mb[0] = nb[0]; mb[1] = nb[1];
  endtask

  task automatic idle(input bit m, input string tag);
    drive(m, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, tag);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
  endtask

  initial begin
    #2000000;
    misses++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; master_mode = 1'b1;
    l_en = 0; l_we = 0; l_addr = '0; l_wdata = '0; l_busy_in_n = 1;
    r_en = 0; r_we = 0; r_addr = '0; r_wdata = '0; r_busy_in_n = 1;
    for (int p = 0; p < 2; p++) begin
      pend_en[p] = 0; pend_we[p] = 0; pend_addr[p] = 0; pend_data[p] = 0;
      pend_tag[p] = "init"; mb[p] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    vectors++;
    if (l_busy_n !== 1'b1 || r_busy_n !== 1'b1) begin
      misses++;
      $display("FAIL R2 reset busy actual=%b%b expected=11", l_busy_n, r_busy_n);
    end
    #1 rst_n = 1'b1;

    // R8: different addresses, both writes in one cycle, no busy
    drive(1, 1, 1, 5, 'hA1, 1, 1, 9, 'hB2, 1, 1, "R8 parallel writes");
    drive(1, 1, 1, 60, 'h0F, 1, 1, 61, 'hF0, 1, 1, "R8 parallel writes 2");
    // R1: cross reads
    drive(1, 1, 0, 9, 0, 1, 0, 5, 0, 1, 1, "R1 cross read");
    drive(1, 1, 0, 60, 0, 1, 0, 61, 0, 1, 1, "R1 read back");
    // R5: same-cycle tie on a fresh address, both writing
    drive(1, 1, 1, 20, 'h11, 1, 1, 20, 'h22, 1, 1, "R5 tie left wins");
    // R7: owner holds, loser reads stored word while flagged
    drive(1, 1, 0, 20, 0, 1, 0, 20, 0, 1, 1, "R7 busy side reads");
    // R10: left leaves, right busy clears a cycle later; right write commits
    drive(1, 0, 0, 0, 0, 1, 1, 20, 'h33, 1, 1, "R10 release");
    drive(1, 1, 0, 20, 0, 0, 0, 0, 0, 1, 1, "R10 read after release");
    // R4: right establishes first, left arrives late
    drive(1, 0, 0, 0, 0, 1, 1, 30, 'h44, 1, 1, "R4 right first");
    drive(1, 1, 1, 30, 'h55, 1, 0, 30, 0, 1, 1, "R4 late left busy");
    drive(1, 1, 1, 30, 'h66, 1, 0, 30, 0, 1, 1, "R4 owner keeps");
    drive(1, 1, 0, 30, 0, 1, 0, 30, 0, 1, 1, "R7 busy left reads");
    drive(1, 1, 0, 30, 0, 0, 0, 0, 0, 1, 1, "R10 left alone");
    // R3: collision of reads only still flags busy, then right write blocked
    drive(1, 1, 0, 9, 0, 1, 0, 9, 0, 1, 1, "R3 read-only tie");
    drive(1, 1, 0, 9, 0, 1, 1, 9, 'h77, 1, 1, "R3 blocked write");
    drive(1, 1, 0, 9, 0, 0, 0, 0, 0, 1, 1, "R7 value kept");
    // R6 is covered by every busy comparison above and below
    idle(1, "R6 idle");
    // R9: follower mode, outputs quiet, busy input blocks one write
    idle(0, "R9 enter follower");
    drive(0, 1, 1, 60, 'hC1, 1, 1, 61, 'hD1, 1, 1, "R9 follower writes");
    drive(0, 1, 0, 5, 0, 1, 0, 9, 0, 0, 1, "R9 left inhibit");
    drive(0, 1, 0, 60, 0, 1, 0, 61, 0, 1, 1, "R9 read back");
    drive(0, 1, 1, 5, 'h5A, 1, 1, 9, 'h9A, 1, 1, "R9 both write");
    drive(0, 1, 0, 9, 0, 1, 0, 5, 0, 1, 0, "R9 right inhibit");
    drive(0, 1, 0, 5, 0, 1, 0, 9, 0, 1, 1, "R9 read back 2");
    idle(0, "R9 flush");
    idle(1, "R2 back to arbiter");
    idle(1, "R2 flush");
    @(negedge clk); @(negedge clk);
    summary();
    $finish;
  end

endmodule